// File: doc/BRIEF.md
# Multi-Cycle Operand Read Master for a Sized Asynchronous Bus

This block fetches one operand per request over an asynchronous external bus whose slaves may be 8, 16 or 32 bits wide. A request gives a byte address, an operand length of one to four bytes and an address-space code. The block runs one or more external bus cycles. Each cycle begins with a one-clock start strobe. A second strobe marks only the first cycle of the operand. The slave ends each cycle with a two-bit acknowledge that also reports its port width. The block counts the bytes delivered in each cycle, moves the address forward and repeats until the operand is complete. It steers each delivered byte lane into its place in the operand.

Requests enter through a valid/ready pair. `req_ready` is high only while the block is idle, so a request is taken on the rising edge where `req_valid` and `req_ready` are both high. The assembled operand leaves through a valid/ready pair. `rsp_valid` and `rsp_data` hold steady until the consumer raises `rsp_ready`. No new request is taken before that handshake completes.

Top module: `rd_bus_master`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `rsp_valid`=0, `bus_cyc_n`=`bus_opstart_n`=`bus_act_n`=1 and `bus_buf_en`=0.
- R2: Each external cycle opens with `bus_cyc_n` low for exactly one clock. In that clock `bus_rnw`=1 and `bus_buf_en`=0, and `bus_addr`, `bus_space`, `bus_siz` and `bus_nocache` are valid. `bus_nocache` and `bus_space` copy the request's values.
- R3: `bus_opstart_n` is low together with `bus_cyc_n` on the first external cycle of an operand only. It stays high on every follow-on cycle.
- R4: After the start clock, `bus_act_n` stays low and `bus_buf_en` is 1 while `bus_ack_n`=11 (not ready). Wait states are inserted with the address held and no new cycle started.
- R5: `bus_ack_n` reports the slave's port width: 00 means 32-bit, 01 means 16-bit and 10 means 8-bit. One cycle moves min(remaining, 4−addr[1:0]) bytes from a 32-bit port, min(remaining, 2−addr[0]) bytes from a 16-bit port, and 1 byte from an 8-bit port. After each acknowledged cycle the address grows by that count and the remaining count shrinks by it. Another cycle follows while bytes remain.
- R6: `req_size` and `bus_siz` share one code: 01 means 1 byte, 10 means 2 bytes, 11 means 3 bytes and 00 means 4 bytes. `bus_siz` shows the bytes still outstanding.
- R7: Byte lanes work as follows. A 32-bit port places the byte at address offset a (a = addr mod 4) on `bus_data[31-8a -: 8]`. A 16-bit port places the even-address byte on bits 31:24 and the odd-address byte on bits 23:16. An 8-bit port uses bits 31:24. Unused lanes are ignored.
- R8: The operand is big-endian and right-justified. The byte at the request address is the most significant byte of the N-byte result. The byte at address+N−1 lands in bits 7:0, and the bits above 8N are zero.
- R9: `rsp_valid` rises one clock after the final acknowledged cycle. It holds with stable `rsp_data` until `rsp_ready` is high on a clock edge. `req_ready` is 0 from request acceptance until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | Operand length code (R6) |
| req_space | input | 3 | Address-space code |
| req_nocache | input | 1 | Per-access cache-inhibit flag |
| rsp_valid | output | 1 | Assembled operand available |
| rsp_ready | input | 1 | Consumer takes the operand |
| rsp_data | output | 32 | Right-justified operand |
| bus_addr | output | 32 | External address |
| bus_space | output | 3 | External address-space code |
| bus_siz | output | 2 | Bytes still requested (R6 code) |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_cyc_n | output | 1 | Active-low start of each external cycle |
| bus_opstart_n | output | 1 | Active-low start of an operand's first cycle |
| bus_act_n | output | 1 | Active-low cycle-in-progress strobe |
| bus_buf_en | output | 1 | Data-buffer enable, 0 in the start clock |
| bus_nocache | output | 1 | Cache-inhibit out |
| bus_ack_n | input | 2 | Active-low acknowledge and port width |
| bus_data | input | 32 | Read data lanes |

## Verification
The checks assume that a slave acknowledges only while `bus_act_n` is low after the start clock. The slave must hold `bus_ack_n` and `bus_data` steady until it sees `bus_act_n` rise. The checks also assume that a request never names a length larger than the bytes its address span allows. The bench slave model acts on the falling edge. It releases its acknowledge once the strobe negates and fills unused lanes with a filler pattern, so that a steering error shows up in the result. Requests are offered only while `req_ready` is high, and the bench holds off `rsp_ready` for a few clocks to test the response hold.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_END,
    ST_RESP
  } rdm_state_e;

  localparam logic [1:0] ACK_P32  = 2'b00;
  localparam logic [1:0] ACK_P16  = 2'b01;
  localparam logic [1:0] ACK_P8   = 2'b10;
  localparam logic [1:0] ACK_NONE = 2'b11;

  // length code to byte count: 00 means four bytes
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction

  function automatic logic [2:0] port_bytes(input logic [1:0] ack);
    case (ack)
      ACK_P32: return 3'd4;
      ACK_P16: return 3'd2;
      ACK_P8:  return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // bytes moved by one acknowledged cycle
  function automatic logic [2:0] xfer_count(input logic [2:0] rem,
                                            input logic [1:0] alo,
                                            input logic [1:0] ack);
    logic [2:0] room;
    case (ack)
      ACK_P32: room = 3'd4 - {1'b0, alo};
      ACK_P16: room = 3'd2 - {2'b00, alo[0]};
      ACK_P8:  room = 3'd1;
      default: room = 3'd0;
    endcase
    return (rem < room) ? rem : room;
  endfunction

endpackage

// File: rtl/rdm_seq.sv
module rdm_seq
  import rdm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SPACE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [SPACE_W-1:0] req_space,
  input  logic               req_nocache,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [SPACE_W-1:0] bus_space,
  output logic [1:0]         bus_siz,
  output logic               bus_rnw,
  output logic               bus_cyc_n,
  output logic               bus_opstart_n,
  output logic               bus_act_n,
  output logic               bus_buf_en,
  output logic               bus_nocache,
  input  logic [1:0]         bus_ack_n,
  output logic               clr,
  output logic               take,
  output logic [2:0]         cnt,
  output logic [2:0]         done_cnt,
  output logic [2:0]         total
);

  rdm_state_e         state;
  logic [ADDR_W-1:0]  addr_q;
  logic [SPACE_W-1:0] space_q;
  logic               nc_q;
  logic [2:0]         total_q;
  logic [2:0]         rem_q;
  logic               first_q;

  assign req_ready = (state == ST_IDLE);
  assign clr       = req_ready && req_valid;
  assign cnt       = xfer_count(rem_q, addr_q[1:0], bus_ack_n);
  assign take      = (state == ST_WAIT) && (bus_ack_n != ACK_NONE);
  assign done_cnt  = total_q - rem_q;
  assign total     = total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      space_q <= '0;
      nc_q    <= 1'b0;
      total_q <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          space_q <= req_space;
          nc_q    <= req_nocache;
          total_q <= size_bytes(req_size);
          rem_q   <= size_bytes(req_size);
          first_q <= 1'b1;
          state   <= ST_START;
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT: if (take) begin
          addr_q  <= addr_q + ADDR_W'(cnt);
          rem_q   <= rem_q - cnt;
          first_q <= 1'b0;
          state   <= ST_END;
        end
        ST_END:  state <= (rem_q == 3'd0) ? ST_RESP : ST_START;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = (state == ST_RESP);
  assign bus_cyc_n     = !(state == ST_START);
  assign bus_opstart_n = !((state == ST_START) && first_q);
  assign bus_act_n     = !((state == ST_START) || (state == ST_WAIT));
  assign bus_buf_en    = (state == ST_WAIT);
  assign bus_rnw       = 1'b1;
  assign bus_addr      = addr_q;
  assign bus_space     = space_q;
  assign bus_nocache   = nc_q;
  assign bus_siz       = rem_q[1:0];

  p_cyc_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc_n |=> bus_cyc_n);
  p_buf_off_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc_n |-> (!bus_buf_en && bus_rnw && !bus_act_n));
  p_opstart_with_cyc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_opstart_n |-> !bus_cyc_n);
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_act_n && bus_cyc_n && bus_ack_n == ACK_NONE)
      |=> (!bus_act_n && bus_cyc_n && $stable(bus_addr)));
  p_progress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (rem_q < $past(rem_q)));

endmodule

// File: rtl/rdm_steer.sv
module rdm_steer
  import rdm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] bus_data,
  input  logic [1:0]         ack,
  input  logic [1:0]         alo,
  input  logic [2:0]         cnt,
  input  logic [2:0]         done_cnt,
  input  logic [2:0]         total,
  output logic [LANES-1:0]   we,
  output logic [LANES*8-1:0] wdata
);

  localparam int MASK_ALL = LANES - 1;

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    logic       we_j;
    logic [7:0] byte_j;
    always_comb begin
      we_j   = 1'b0;
      byte_j = 8'h00;
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(cnt) &&
            (int'(total) - 1 - int'(done_cnt) - k) == j) begin
          we_j   = 1'b1;
          byte_j = bus_data[(MASK_ALL - ((int'(alo) + k) &
                   (int'(port_bytes(ack)) - 1))) * 8 +: 8];
        end
      end
    end
    assign we[j]           = we_j;
    assign wdata[j*8 +: 8] = byte_j;
  end

endmodule

// File: rtl/rdm_operand.sv
module rdm_operand #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               take,
  input  logic [LANES-1:0]   we,
  input  logic [LANES*8-1:0] wdata,
  output logic [LANES*8-1:0] q
);

  for (genvar j = 0; j < LANES; j++) begin : g_reg
    logic [7:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              b_q <= 8'h00;
      else if (clr)            b_q <= 8'h00;
      else if (take && we[j])  b_q <= wdata[j*8 +: 8];
    end
    assign q[j*8 +: 8] = b_q;
  end

  p_write_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we != '0) |-> take);

endmodule

// File: rtl/rd_bus_master.sv
module rd_bus_master #(
  parameter int ADDR_W  = 32,
  parameter int SPACE_W = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [SPACE_W-1:0] req_space,
  input  logic               req_nocache,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [SPACE_W-1:0] bus_space,
  output logic [1:0]         bus_siz,
  output logic               bus_rnw,
  output logic               bus_cyc_n,
  output logic               bus_opstart_n,
  output logic               bus_act_n,
  output logic               bus_buf_en,
  output logic               bus_nocache,
  input  logic [1:0]         bus_ack_n,
  input  logic [DATA_W-1:0]  bus_data
);

  localparam int LANES = DATA_W / 8;

  logic             clr, take;
  logic [2:0]       cnt, done_cnt, total;
  logic [LANES-1:0] we;
  logic [DATA_W-1:0] wdata;

  rdm_seq #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_space(req_space), .req_nocache(req_nocache),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .bus_addr(bus_addr), .bus_space(bus_space), .bus_siz(bus_siz),
    .bus_rnw(bus_rnw), .bus_cyc_n(bus_cyc_n), .bus_opstart_n(bus_opstart_n),
    .bus_act_n(bus_act_n), .bus_buf_en(bus_buf_en), .bus_nocache(bus_nocache),
    .bus_ack_n(bus_ack_n),
    .clr(clr), .take(take), .cnt(cnt), .done_cnt(done_cnt), .total(total)
  );

  rdm_steer #(.LANES(LANES)) u_steer (
    .bus_data(bus_data), .ack(bus_ack_n), .alo(bus_addr[1:0]),
    .cnt(cnt), .done_cnt(done_cnt), .total(total),
    .we(we), .wdata(wdata)
  );

  rdm_operand #(.LANES(LANES)) u_opnd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take),
    .we(we), .wdata(wdata), .q(rsp_data)
  );

  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

// File: tb/rd_bus_master_tb.sv
module rd_bus_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [2:0]  req_space = '0;
  logic        req_nocache = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic [31:0] bus_addr;
  logic [2:0]  bus_space;
  logic [1:0]  bus_siz;
  logic        bus_rnw, bus_cyc_n, bus_opstart_n, bus_act_n, bus_buf_en, bus_nocache;
  logic [1:0]  bus_ack_n = 2'b11;
  logic [31:0] bus_data = '0;

  always #4 clk = ~clk;

  rd_bus_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_space(req_space), .req_nocache(req_nocache),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bus_addr(bus_addr), .bus_space(bus_space), .bus_siz(bus_siz),
    .bus_rnw(bus_rnw), .bus_cyc_n(bus_cyc_n), .bus_opstart_n(bus_opstart_n),
    .bus_act_n(bus_act_n), .bus_buf_en(bus_buf_en), .bus_nocache(bus_nocache),
    .bus_ack_n(bus_ack_n), .bus_data(bus_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [31:0] a);
    return (a[7:0] ^ 8'hA5) + {6'd0, a[9:8]};
  endfunction

  // slave configuration and bench-side model state
  logic [1:0]  port_ack = 2'b00;
  int          wait_n = 0;
  int          wcnt = 0;
  logic [31:0] exp_addr;
  int          exp_rem;
  logic [2:0]  exp_space;
  logic        exp_nc;
  bit          exp_first;
  int          cyc_seen, ocs_seen;
  bit          mon_on = 1'b0;

  function automatic int bench_count(input int rem, input logic [31:0] a,
                                     input logic [1:0] p);
    int room;
    room = (p == 2'b00) ? 4 - int'(a[1:0]) : (p == 2'b01) ? 2 - int'(a[0]) : 1;
    return (rem < room) ? rem : room;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (!bus_cyc_n) begin
        cyc_seen++;
        if (!bus_opstart_n) ocs_seen++;
        chk(bus_rnw && !bus_buf_en, "R2 start-clock rnw/buf", {30'd0, bus_rnw, bus_buf_en}, 32'h2);
        chk(bus_addr == exp_addr, "R5 cycle address", bus_addr, exp_addr);
        chk(bus_siz == 2'(exp_rem), "R6 size code", {30'd0, bus_siz}, 32'(exp_rem & 3));
        chk(bus_space == exp_space && bus_nocache == exp_nc, "R2 space/nocache",
            {28'd0, bus_space, bus_nocache}, {28'd0, exp_space, exp_nc});
        chk(bus_opstart_n == !exp_first, "R3 operand start strobe",
            {31'd0, bus_opstart_n}, {31'd0, !exp_first});
        exp_first = 1'b0;
      end
      if (!bus_act_n && bus_cyc_n) begin
        chk(bus_buf_en && bus_addr == exp_addr, "R4 data phase hold", bus_addr, exp_addr);
      end
    end
    // slave model
    if (!bus_act_n && bus_cyc_n) begin
      if (wcnt < wait_n) begin
        wcnt++;
        bus_ack_n = 2'b11;
      end else if (bus_ack_n == 2'b11) begin
        bus_ack_n = port_ack;
        bus_data  = 32'hEEEE_EEEE;
        if (port_ack == 2'b00) begin
          for (int l = 0; l < 4; l++)
            bus_data[l*8 +: 8] = mem({bus_addr[31:2], 2'(3 - l)});
        end else if (port_ack == 2'b01) begin
          bus_data[31:24] = mem({bus_addr[31:1], 1'b0});
          bus_data[23:16] = mem({bus_addr[31:1], 1'b1});
        end else begin
          bus_data[31:24] = mem(bus_addr);
        end
        begin
          int c;
          c = bench_count(exp_rem, exp_addr, port_ack);
          exp_addr = exp_addr + 32'(c);
          exp_rem  = exp_rem - c;
        end
      end
    end else begin
      wcnt = 0;
      bus_ack_n = 2'b11;
    end
  end

  task automatic do_read(input string tag, input logic [31:0] a, input logic [1:0] sz,
                         input logic [1:0] port, input int waits,
                         input logic [2:0] sp, input logic nc);
    int n, exp_cyc, rem;
    logic [31:0] ea, exp_val;
    n = (sz == 2'b00) ? 4 : int'(sz);
    exp_val = '0;
    for (int k = 0; k < n; k++) exp_val |= 32'(mem(a + 32'(k))) << (8 * (n - 1 - k));
    exp_cyc = 0; rem = n; ea = a;
    while (rem > 0) begin
      int c;
      c = bench_count(rem, ea, port);
      ea += 32'(c); rem -= c; exp_cyc++;
    end
    port_ack = port; wait_n = waits;
    exp_addr = a; exp_rem = n; exp_space = sp; exp_nc = nc; exp_first = 1'b1;
    cyc_seen = 0; ocs_seen = 0; mon_on = 1'b1;
    @(negedge clk);
    chk(req_ready, {tag, " R9 ready when idle"}, {31'd0, req_ready}, 32'd1);
    req_addr = a; req_size = sz; req_space = sp; req_nocache = nc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {tag, " R9 busy after accept"}, {31'd0, req_ready}, 32'd0);
    for (int t = 0; t < 200 && !rsp_valid; t++) @(negedge clk);
    chk(rsp_data == exp_val, {tag, " R8 R7 operand"}, rsp_data, exp_val);
    chk(cyc_seen == exp_cyc, {tag, " R5 cycle count"}, 32'(cyc_seen), 32'(exp_cyc));
    chk(ocs_seen == 1, {tag, " R3 operand start count"}, 32'(ocs_seen), 32'd1);
    repeat (2) @(negedge clk);
    chk(rsp_valid && rsp_data == exp_val && !req_ready, {tag, " R9 response held"},
        rsp_data, exp_val);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, {tag, " R9 released"}, {31'd0, rsp_valid}, 32'd0);
    mon_on = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 idle handshake", {30'd0, req_ready, rsp_valid}, 32'h2);
    chk(bus_cyc_n && bus_opstart_n && bus_act_n && !bus_buf_en, "R1 strobes idle",
        {28'd0, bus_cyc_n, bus_opstart_n, bus_act_n, bus_buf_en}, 32'hE);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_wide_port;
    do_read("byte32", 32'h0000_1003, 2'b01, 2'b00, 0, 3'd1, 1'b0);
    do_read("word32", 32'h0000_1002, 2'b10, 2'b00, 0, 3'd5, 1'b1);
    do_read("long32", 32'h0000_2000, 2'b00, 2'b00, 0, 3'd2, 1'b0);
    do_read("three32", 32'h0000_2001, 2'b11, 2'b00, 0, 3'd6, 1'b0);
    do_read("long32mis", 32'h0000_2103, 2'b00, 2'b00, 0, 3'd1, 1'b0);
  endtask

  task automatic t_narrow_ports;
    do_read("long8", 32'h0000_3000, 2'b00, 2'b10, 0, 3'd1, 1'b1);
    do_read("long16", 32'h0000_3200, 2'b00, 2'b01, 0, 3'd2, 1'b0);
    do_read("long16mis", 32'h0000_3301, 2'b00, 2'b01, 0, 3'd2, 1'b0);
    do_read("three8", 32'h0000_3102, 2'b11, 2'b10, 0, 3'd3, 1'b0);
  endtask

  task automatic t_wait_states;
    do_read("wait32", 32'h0000_0204, 2'b00, 2'b00, 3, 3'd7, 1'b1);
    do_read("wait16", 32'h0000_0301, 2'b11, 2'b01, 2, 3'd4, 1'b0);
  endtask

  initial begin
    t_reset();
    t_wide_port();
    t_narrow_ports();
    t_wait_states();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule